// File: doc/BRIEF.md
# Interrupt Level and Mode Controller

This block sits beside the instruction sequencer of a small 16-bit controller and decides which of four register banks is live. Three active-low interrupt request lines are synchronized and held in request flip-flops that follow the line level. A fixed priority mapping turns the request vector into a level from 0 to 3. The sequencer raises a boundary strobe between instructions. On that strobe, when interrupts are enabled and the mapped level differs from the current one, the level moves to the mapped value. This applies in both directions, so a released request drops the level back down. The same cycle the block emits a one-cycle change pulse, which the datapath uses to switch to the bank whose register 0 holds the program counter.

The block also decodes control bytes written to the control device address. The control bits are numbered from the most significant end. Two of them gate the interrupt-enable flip-flop, with disable winning. A third issues a state-transition command: it leaves the initial-load phase and toggles a storage-switch flip-flop. A storage-select output is high only when the switch flip-flop is set and the initial-load flip-flop is clear.

Top module: `irq_mode_ctl`

## Requirements
- R1: While and after reset, level is 0, level_changed is 0, int_enable is 0, init_load is 1, store_sw is 1 and store_sel is 0.
- R2: Request lines are active low and are not latched: a line driven back high clears its request, and at the next enabled boundary the level falls to the value mapped from the remaining requests.
- R3: The request vector {irq_n[2], irq_n[1], irq_n[0]} inverted maps to a level as follows: any request on line 2 gives 3; otherwise a request on line 1 gives 2; otherwise a request on line 0 gives 1; no request gives 0.
- R4: level changes only in a cycle where insn_boundary is high and int_enable is set. With enable clear, or with no boundary, it holds.
- R5: level_changed is high for exactly the one cycle in which a new level is first visible. It stays low when a boundary finds the mapped level equal to the current one.
- R6: A control byte acts only when ctl_wr is high and ctl_addr equals 0. Writes to any other address, and address 0 with ctl_wr low, leave int_enable, init_load and store_sw unchanged.
- R7: With control bits numbered from the MSB (bit n has weight 2^(7-n)), bit 1 (0x40) low clears int_enable. Otherwise bit 2 (0x20) low sets it. When both are low, enable ends clear.
- R8: Control bit 5 (0x04) low clears init_load and inverts store_sw on that write.
- R9: store_sel is high exactly when store_sw is 1 and init_load is 0, and it follows every state-transition command in the cycle after the write.
- R10: Control bits 0, 3, 4, 6 and 7 (0x80, 0x10, 0x08, 0x02, 0x01) have no effect on int_enable, init_load or store_sw.
- R11: A request line change passes through SYNC_STAGES synchronizer flops and one request flop. A boundary taken in the first SYNC_STAGES+1 clock edges after the change still uses the old requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n | input | 3 | Active-low interrupt request lines, asynchronous |
| insn_boundary | input | 1 | High for one cycle between instructions |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_addr | input | 4 | Device address of the control write |
| ctl_data | input | 8 | Control byte |
| level | output | 2 | Current interrupt level, selects the register bank |
| level_changed | output | 1 | One-cycle pulse when level takes a new value |
| int_enable | output | 1 | Interrupt-enable flip-flop |
| init_load | output | 1 | Initial-load flip-flop |
| store_sw | output | 1 | Storage-switch flip-flop |
| store_sel | output | 1 | Storage-select output |

## Verification
The bench walks every ordered pair of request vectors through two enabled boundaries. A wrong priority squash would put vectors 3 or 5..7 on the wrong level, and a latched request would fail to fall back when lines are released. It writes a byte with both enable bits low, where a design that let set win would leave interrupts on. It also holds the boundary high across the synchronizer latency, so a design that was short of flops would change level early. It then sweeps all non-zero addresses with an all-zero byte and clears each ignored control bit on its own. Any decode leak shows up as a flipped enable or mode bit. Repeated transition commands confirm that store_sel stays low until initial load ends and then alternates.

// File: rtl/irq_mode_pkg.sv
package irq_mode_pkg;

   localparam int unsigned LVL_W   = 2;
   localparam int unsigned REQ_W   = 3;

   typedef logic [LVL_W-1:0] lvl_t;
   typedef logic [REQ_W-1:0] req_t;

   typedef struct packed {
      logic ie_clr;
      logic ie_set;
      logic xfer;
   } ctl_cmd_t;

   // priority squash: top line wins, then middle, then bottom
   function automatic lvl_t map_level(input req_t req);
      lvl_t l;
      if (req[2])
         l = lvl_t'(3);
      else if (req[1])
         l = lvl_t'(2);
      else if (req[0])
         l = lvl_t'(1);
      else
         l = lvl_t'(0);
      return l;
   endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] line_async_n,
   output logic [WIDTH-1:0] line_sync_n
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign line_sync_n = line_async_n;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
               always_ff @(posedge clk) begin
                  if (!rst_n)
                     stage_q[s] <= '1;
                  else
                     stage_q[s] <= line_async_n;
               end
            end else begin : g_next
               always_ff @(posedge clk) begin
                  if (!rst_n)
                     stage_q[s] <= '1;
                  else
                     stage_q[s] <= stage_q[s-1];
               end
            end
         end
         assign line_sync_n = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/irq_level_unit.sv
module irq_level_unit
   import irq_mode_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  req_t line_sync_n,
   input  logic insn_boundary,
   input  logic int_enable,
   output req_t req,
   output lvl_t level,
   output logic level_changed
);

   req_t req_q;
   lvl_t level_q;
   logic chg_q;
   lvl_t mapped;
   logic take;

   always_comb begin
      mapped = map_level(req_q);
      take   = insn_boundary && int_enable && (mapped != level_q);
   end

   // request flops track the line level, no latching
   always_ff @(posedge clk) begin
      if (!rst_n)
         req_q <= '0;
      else
         req_q <= ~line_sync_n;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_q <= '0;
         chg_q   <= 1'b0;
      end else begin
         chg_q <= take;
         if (take)
            level_q <= mapped;
      end
   end

   assign req           = req_q;
   assign level         = level_q;
   assign level_changed = chg_q;

endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
   import irq_mode_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned CTL_ADDR = 0
) (
   input  logic              ctl_wr,
   input  logic [ADDR_W-1:0] ctl_addr,
   input  logic [DATA_W-1:0] ctl_data,
   output ctl_cmd_t          cmd
);

   // control bits are numbered from the MSB
   localparam int unsigned IE_OFF_POS = DATA_W - 1 - 1;
   localparam int unsigned IE_ON_POS  = DATA_W - 1 - 2;
   localparam int unsigned XFER_POS   = DATA_W - 1 - 5;

   logic hit;
   logic unused_bits;

   always_comb begin
      hit        = ctl_wr && (ctl_addr == ADDR_W'(CTL_ADDR));
      cmd.ie_clr = hit && !ctl_data[IE_OFF_POS];
      cmd.ie_set = hit && ctl_data[IE_OFF_POS] && !ctl_data[IE_ON_POS];
      cmd.xfer   = hit && !ctl_data[XFER_POS];
   end

   // remaining control bits carry nothing for this block
   assign unused_bits = ^ctl_data;

endmodule

// File: rtl/mode_regs.sv
module mode_regs
   import irq_mode_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  ctl_cmd_t cmd,
   output logic     int_enable,
   output logic     init_load,
   output logic     store_sw,
   output logic     store_sel
);

   logic ie_q;
   logic il_q;
   logic ms_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_q <= 1'b0;
         il_q <= 1'b1;
         ms_q <= 1'b1;
      end else begin
         if (cmd.ie_clr)
            ie_q <= 1'b0;
         else if (cmd.ie_set)
            ie_q <= 1'b1;
         if (cmd.xfer) begin
            il_q <= 1'b0;
            ms_q <= ~ms_q;
         end
      end
   end

   assign int_enable = ie_q;
   assign init_load  = il_q;
   assign store_sw   = ms_q;
   assign store_sel  = ms_q && !il_q;

endmodule

// File: rtl/irq_mode_ctl.sv
module irq_mode_ctl
   import irq_mode_pkg::*;
#(
   parameter int unsigned NUM_IRQ     = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned CTL_ADDR    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IRQ-1:0] irq_n,
   input  logic              insn_boundary,
   input  logic              ctl_wr,
   input  logic [ADDR_W-1:0] ctl_addr,
   input  logic [DATA_W-1:0] ctl_data,
   output logic [LVL_W-1:0]  level,
   output logic              level_changed,
   output logic              int_enable,
   output logic              init_load,
   output logic              store_sw,
   output logic              store_sel
);

   generate
      if (NUM_IRQ != REQ_W) begin : g_bad_irq
         $error("irq_mode_ctl: NUM_IRQ must equal the mapped request width");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("irq_mode_ctl: control byte needs at least 8 bits");
      end
      if (CTL_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("irq_mode_ctl: CTL_ADDR does not fit ADDR_W");
      end
   endgenerate

   req_t     line_sync_n;
   req_t     req;
   ctl_cmd_t cmd;

   irq_sync #(
      .WIDTH  (NUM_IRQ),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk          (clk),
      .rst_n        (rst_n),
      .line_async_n (irq_n),
      .line_sync_n  (line_sync_n)
   );

   ctl_decode #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .CTL_ADDR (CTL_ADDR)
   ) u_dec (
      .ctl_wr   (ctl_wr),
      .ctl_addr (ctl_addr),
      .ctl_data (ctl_data),
      .cmd      (cmd)
   );

   mode_regs u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd        (cmd),
      .int_enable (int_enable),
      .init_load  (init_load),
      .store_sw   (store_sw),
      .store_sel  (store_sel)
   );

   irq_level_unit u_lvl (
      .clk           (clk),
      .rst_n         (rst_n),
      .line_sync_n   (line_sync_n),
      .insn_boundary (insn_boundary),
      .int_enable    (int_enable),
      .req           (req),
      .level         (level),
      .level_changed (level_changed)
   );

endmodule

module irq_mode_ctl_chk
   import irq_mode_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned CTL_ADDR = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              insn_boundary,
   input logic              ctl_wr,
   input logic [ADDR_W-1:0] ctl_addr,
   input logic [DATA_W-1:0] ctl_data,
   input lvl_t              level,
   input logic              level_changed,
   input logic              int_enable,
   input logic              init_load,
   input logic              store_sw,
   input req_t              req
);

   logic hit;
   assign hit = ctl_wr && (ctl_addr == ADDR_W'(CTL_ADDR));

   // R4
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!insn_boundary || !int_enable) |=> $stable(level));

   // R5
   change_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level_changed |-> !$stable(level));

   // R3
   mapped_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level_changed |-> (level == map_level($past(req))));

   // R6
   addr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> ($stable(int_enable) && $stable(init_load) && $stable(store_sw)));

   // R7
   ie_off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !ctl_data[DATA_W-2]) |=> !int_enable);

   // R8
   xfer_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !ctl_data[DATA_W-6]) |=> (!init_load && (store_sw != $past(store_sw))));

endmodule

bind irq_mode_ctl irq_mode_ctl_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .CTL_ADDR (CTL_ADDR)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .insn_boundary (insn_boundary),
   .ctl_wr        (ctl_wr),
   .ctl_addr      (ctl_addr),
   .ctl_data      (ctl_data),
   .level         (level),
   .level_changed (level_changed),
   .int_enable    (int_enable),
   .init_load     (init_load),
   .store_sw      (store_sw),
   .req           (req)
);

// File: tb/sim_irq_mode_ctl.sv
module sim_irq_mode_ctl;

   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;
   localparam int LAT        = SYNC + 1;

   logic       clk;
   logic       rst_n;
   logic [2:0] irq_n;
   logic       insn_boundary;
   logic       ctl_wr;
   logic [3:0] ctl_addr;
   logic [7:0] ctl_data;
   logic [1:0] level;
   logic       level_changed;
   logic       int_enable;
   logic       init_load;
   logic       store_sw;
   logic       store_sel;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 0;

   irq_mode_ctl #(.SYNC_STAGES(SYNC)) u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .irq_n         (irq_n),
      .insn_boundary (insn_boundary),
      .ctl_wr        (ctl_wr),
      .ctl_addr      (ctl_addr),
      .ctl_data      (ctl_data),
      .level         (level),
      .level_changed (level_changed),
      .int_enable    (int_enable),
      .init_load     (init_load),
      .store_sw      (store_sw),
      .store_sel     (store_sel)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string rq, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
      end
   endtask

   function automatic int exp_lvl(input int v);
      return (v >= 4) ? 3 : (v >= 2) ? 2 : v;
   endfunction

   task automatic ctl(input int a, input int d);
      ctl_wr   = 1'b1;
      ctl_addr = 4'(a);
      ctl_data = 8'(d);
      @(negedge clk);
      ctl_wr   = 1'b0;
   endtask

   task automatic drive_irq(input int v);
      irq_n = ~3'(v);
      repeat (LAT + 1) @(negedge clk);
   endtask

   task automatic boundary();
      insn_boundary = 1'b1;
      @(negedge clk);
      insn_boundary = 1'b0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog (all requirements): actual hung expected done");
         summary();
         $finish;
      end
   end

   initial begin
      int prev;
      int ie0, il0, ms0;
      rst_n = 1'b0; irq_n = 3'b111; insn_boundary = 1'b0;
      ctl_wr = 1'b0; ctl_addr = '0; ctl_data = '0;
      repeat (3) @(negedge clk);
      // R1 during reset
      check("R1 level", level, 0);
      check("R1 ie", int_enable, 0);
      check("R1 init_load", init_load, 1);
      check("R1 store_sw", store_sw, 1);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 after release
      check("R1 level_changed", level_changed, 0);
      check("R9 store_sel blocked by init_load", store_sel, 0);

      // R4 boundary with enable clear holds
      irq_n = 3'b110;
      repeat (LAT + 1) @(negedge clk);
      boundary();
      check("R4 disabled hold", level, 0);
      drive_irq(0);

      // R7 enable, disable priority
      ctl(0, 8'hDF);
      check("R7 set", int_enable, 1);
      ctl(0, 8'h9F);
      check("R7 clear wins", int_enable, 0);
      ctl(0, 8'hFF);
      check("R7 neither", int_enable, 0);
      ctl(0, 8'hDF);
      check("R7 set again", int_enable, 1);

      // R11 synchronizer latency
      irq_n = 3'b110;
      insn_boundary = 1'b1;
      for (int k = 0; k < LAT; k++) begin
         @(negedge clk);
         check("R11 old level during latency", level, 0);
      end
      @(negedge clk);
      insn_boundary = 1'b0;
      check("R11 new level", level, 1);
      check("R5 pulse", level_changed, 1);
      @(negedge clk);
      check("R5 pulse one cycle", level_changed, 0);

      // R2 release drops level
      drive_irq(0);
      boundary();
      check("R2 fall back", level, 0);

      // R3 R5 R2 exhaustive pairs
      prev = 0;
      for (int a = 0; a < 8; a++) begin
         for (int b = 0; b < 8; b++) begin
            drive_irq(a);
            boundary();
            check("R3 level a", level, exp_lvl(a));
            check("R5 changed a", level_changed, int'(exp_lvl(a) != prev));
            prev = exp_lvl(a);
            drive_irq(b);
            boundary();
            check("R3 level b", level, exp_lvl(b));
            check("R5 changed b", level_changed, int'(exp_lvl(b) != prev));
            prev = exp_lvl(b);
         end
      end

      // R4 disabled holds level 3, then no boundary holds
      ctl(0, 8'hBF);
      drive_irq(0);
      boundary();
      check("R4 held while disabled", level, 3);
      check("R5 no pulse while disabled", level_changed, 0);
      ctl(0, 8'hDF);
      drive_irq(1);
      repeat (3) @(negedge clk);
      check("R4 held without boundary", level, 3);
      boundary();
      check("R4 update at boundary", level, 1);

      // R6 other addresses ignored
      ie0 = int_enable; il0 = init_load; ms0 = store_sw;
      for (int a = 1; a < 16; a++) begin
         ctl(a, 8'h00);
         check("R6 ie", int_enable, ie0);
         check("R6 init_load", init_load, il0);
         check("R6 store_sw", store_sw, ms0);
      end
      ctl_addr = 4'd0; ctl_data = 8'h00; ctl_wr = 1'b0;
      @(negedge clk);
      check("R6 no strobe ie", int_enable, ie0);
      check("R6 no strobe store_sw", store_sw, ms0);

      // R10 ignored control bits
      for (int i = 0; i < 5; i++) begin
         int m;
         m = (i == 0) ? 8'h80 : (i == 1) ? 8'h10 : (i == 2) ? 8'h08 :
             (i == 3) ? 8'h02 : 8'h01;
         ctl(0, 8'hFF ^ m);
         check("R10 ie", int_enable, ie0);
         check("R10 init_load", init_load, il0);
         check("R10 store_sw", store_sw, ms0);
      end

      // R8 R9 state transitions
      ctl(0, 8'hFB);
      check("R8 init_load cleared", init_load, 0);
      check("R8 toggle 1", store_sw, 0);
      check("R9 sel 1", store_sel, 0);
      ctl(0, 8'hFB);
      check("R8 toggle 2", store_sw, 1);
      check("R9 sel 2", store_sel, 1);
      ctl(0, 8'hFB);
      check("R8 toggle 3", store_sw, 0);
      check("R9 sel 3", store_sel, 0);
      ctl(0, 8'h00);
      check("R7 all low clears", int_enable, 0);
      check("R8 all low toggles", store_sw, 1);
      check("R9 sel 4", store_sel, 1);

      done = 1;
      summary();
      $finish;
   end

endmodule